// File: doc/BRIEF.md
# Virtual-Processor Context Push/Pull Handler

This block serves the hypervisor page of one hardware thread's OS interrupt context. It watches load/store requests into a small address window and acts on two offsets. A store to the push offset installs a new virtual-processor identity word, called the CAM word, in the thread context. If that word is marked valid, the block looks up the saved record of that virtual processor in an internal table. It then moves any pending-priority bits saved in the record into the thread's live pending set, and clears them from the record.

A load from the pull offset returns the current CAM word and clears its valid flag in the same operation. The block forwards every other access, unchanged and in the same cycle, to a port for the legacy handler, and takes no action of its own on it. The thread's pending-priority register always follows the most favoured pending bit. An exception line is raised while that priority is more favoured than the current processor priority. A separate load port fills the record table.

Top module: `vp_ctx_switch`

## Requirements
- R1: A store to the push offset (default 0x118) writes the full 32-bit data into the CAM word. The new value shows on `os_cam` in the cycle after acceptance. CAM layout: bit 31 is the valid flag, bits 27:24 the block number, bits 23:0 the index.
- R2: A push whose bit 31 is clear performs no table lookup. `req_ready` stays high, and `os_ipb` and `ctx_err` do not change.
- R3: A push with bit 31 set holds `req_ready` low for exactly the three cycles after acceptance. While `req_ready` is low, no request is accepted or forwarded.
- R4: The record is selected by the block number. It counts as present only when bit 31 of its word 0 is set and bits 23:0 of its word 1 equal the pushed index. Otherwise `ctx_err` pulses for one cycle, in the second cycle after acceptance. In that case the CAM word keeps the pushed value and `os_ipb` is unchanged.
- R5: If a present record has a non-zero saved pending field (bits 31:24 of word 2), that field is ORed into `os_ipb`. The result is visible in the third cycle after acceptance. The field is cleared in the record and the record's other words are left intact.
- R6: A load from the pull offset (default 0x130) returns the CAM word as it was, with `rsp_valid` high, in the cycle after acceptance. From that cycle on, the stored word has bit 31 cleared and all other bits kept.
- R7: Pulling a word whose bit 31 is already clear pulses `ctx_err` in the cycle after acceptance. The data is still returned.
- R8: Any other access, including a load from the push offset or a store to the pull offset, raises `leg_valid` in the same cycle with the address, data and direction unchanged. It leaves the CAM word untouched.
- R9: `os_pipr` equals the index of the lowest set bit of `os_ipb` (bit n = priority n, 0 most favoured), or 0xFF if none is set. It updates one cycle after `os_ipb` changes. The reset values are `os_ipb` = 0 and `os_pipr` = 0xFF.
- R10: `exc_out` is high exactly while `os_pipr` is numerically lower than `cur_prio`.
- R11: `tbl_we` writes `tbl_data` into word `tbl_word` of entry `tbl_sel` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Window offset |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Pull data valid |
| rsp_rdata | output | 32 | Pulled CAM word |
| leg_valid | output | 1 | Forwarded access to legacy handler |
| leg_write | output | 1 | Forwarded direction |
| leg_addr | output | 12 | Forwarded offset |
| leg_wdata | output | 32 | Forwarded store data |
| tbl_we | input | 1 | Record table write enable |
| tbl_sel | input | 4 | Record entry |
| tbl_word | input | 2 | Word within entry |
| tbl_data | input | 32 | Record word data |
| cur_prio | input | 8 | Current processor priority |
| os_cam | output | 32 | Live CAM word |
| os_ipb | output | 8 | Live pending-priority bits |
| os_pipr | output | 8 | Most favoured pending priority |
| exc_out | output | 1 | Exception request |
| ctx_err | output | 1 | Error pulse |

## Verification
Each result has its own due cycle after the accepting edge:
- The CAM word, pull data, the pull error and the first busy cycle are due one cycle after.
- The record error is due two cycles after.
- The merged pending bits are due three cycles after.
- The pending priority, the exception line and the return of ready are due four cycles after.

The bench drives inputs on the falling edge and samples on each later falling edge. Every check is tied to its exact due cycle, and pulses are also checked to be absent in the neighbouring cycles. Forwarding and stall behaviour are combinational, so they are sampled shortly after the inputs change in the same cycle.

// File: rtl/vpctx_pkg.sv
package vpctx_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WB, ST_SETTLE} seq_st_t;
   typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_PULL, OP_PASS} op_kind_t;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned REC_WORDS = 4;
endpackage

// File: rtl/vpctx_decode.sv
module vpctx_decode
   import vpctx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] PUSH_OFS = 12'h118,
   parameter logic [ADDR_W-1:0] PULL_OFS = 12'h130,
   parameter int unsigned BLK_W    = 4,
   parameter int unsigned IDX_W    = 24
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] cam,
   output op_kind_t          op,
   output logic [BLK_W-1:0]  cam_blk,
   output logic [IDX_W-1:0]  cam_idx,
   output logic              cam_vo
);
   always_comb begin
      op = OP_NONE;
      if (req_valid) begin
         if (req_write && req_addr == PUSH_OFS)       op = OP_PUSH;
         else if (!req_write && req_addr == PULL_OFS) op = OP_PULL;
         else                                         op = OP_PASS;
      end
   end

   assign cam_vo  = cam[WORD_W-1];
   assign cam_blk = cam[IDX_W +: BLK_W];
   assign cam_idx = cam[IDX_W-1:0];
endmodule

// File: rtl/vpctx_table.sv
module vpctx_table
   import vpctx_pkg::*;
#(
   parameter int unsigned BLK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_w0,
   output logic [WORD_W-1:0] rd_w1,
   output logic [WORD_W-1:0] rd_w2,
   input  logic              wb_en,
   input  logic [BLK_W-1:0]  wb_sel,
   input  logic [WORD_W-1:0] wb_data,
   input  logic              ld_en,
   input  logic [BLK_W-1:0]  ld_sel,
   input  logic [1:0]        ld_word,
   input  logic [WORD_W-1:0] ld_data
);
   localparam int unsigned ENTRIES = 1 << BLK_W;
   localparam int unsigned WB_WORD = 2;

   logic [WORD_W-1:0] mem [ENTRIES][REC_WORDS];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      for (genvar w = 0; w < REC_WORDS; w++) begin : g_wrd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e][w] <= '0;
            else if (wb_en && wb_sel == BLK_W'(e) && w == WB_WORD)
               mem[e][w] <= wb_data;
            else if (ld_en && ld_sel == BLK_W'(e) && ld_word == 2'(w))
               mem[e][w] <= ld_data;
         end
      end
   end

   assign rd_w0 = mem[rd_sel][0];
   assign rd_w1 = mem[rd_sel][1];
   assign rd_w2 = mem[rd_sel][2];
endmodule

// File: rtl/vpctx_seq.sv
module vpctx_seq
   import vpctx_pkg::*;
#(
   parameter int unsigned IDX_W     = 24,
   parameter int unsigned PRIO_W    = 8,
   parameter bit          TAG_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] rec_w0,
   input  logic [WORD_W-1:0] rec_w1,
   input  logic [WORD_W-1:0] rec_w2,
   output logic              busy,
   output logic              wb_en,
   output logic [WORD_W-1:0] wb_data,
   output logic              merge_en,
   output logic [PRIO_W-1:0] merge_ipb,
   output logic              rec_err
);
   localparam int unsigned IPB_LSB = WORD_W - PRIO_W;

   seq_st_t           state;
   logic              ok_q;
   logic [PRIO_W-1:0] ipb_q;
   logic [WORD_W-1:0] w2_q;
   logic              tag_ok;

   if (TAG_CHECK) begin : g_tag
      assign tag_ok = (rec_w1[IDX_W-1:0] == idx);
   end else begin : g_notag
      assign tag_ok = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ok_q  <= 1'b0;
         ipb_q <= '0;
         w2_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE:   if (start) state <= ST_LOOK;
            ST_LOOK: begin
               ok_q  <= rec_w0[WORD_W-1] && tag_ok;
               ipb_q <= rec_w2[IPB_LSB +: PRIO_W];
               w2_q  <= rec_w2;
               state <= ST_WB;
            end
            ST_WB:     state <= ST_SETTLE;
            ST_SETTLE: state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign merge_en  = (state == ST_WB) && ok_q && (ipb_q != '0);
   assign wb_en     = merge_en;
   assign merge_ipb = ipb_q;
   assign wb_data   = {{PRIO_W{1'b0}}, w2_q[IPB_LSB-1:0]};
   assign rec_err   = (state == ST_WB) && !ok_q;

   a_r4_err_inside_busy : assert property (@(posedge clk) disable iff (!rst_n)
      rec_err |-> busy && !merge_en);
endmodule

// File: rtl/vp_ctx_switch.sv
module vp_ctx_switch
   import vpctx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] PUSH_OFS = 12'h118,
   parameter logic [ADDR_W-1:0] PULL_OFS = 12'h130,
   parameter int unsigned BLK_W    = 4,
   parameter int unsigned IDX_W    = 24,
   parameter int unsigned PRIO_W   = 8,
   parameter bit          TAG_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              leg_valid,
   output logic              leg_write,
   output logic [ADDR_W-1:0] leg_addr,
   output logic [31:0]       leg_wdata,
   input  logic              tbl_we,
   input  logic [BLK_W-1:0]  tbl_sel,
   input  logic [1:0]        tbl_word,
   input  logic [31:0]       tbl_data,
   input  logic [PRIO_W-1:0] cur_prio,
   output logic [31:0]       os_cam,
   output logic [PRIO_W-1:0] os_ipb,
   output logic [PRIO_W-1:0] os_pipr,
   output logic              exc_out,
   output logic              ctx_err
);
   if (BLK_W + IDX_W > WORD_W - 1) begin : g_bad_cam
      $error("CAM fields overlap the valid flag");
   end
   if (PRIO_W > WORD_W / 2 || (1 << PRIO_W) <= PRIO_W) begin : g_bad_prio
      $error("PRIO_W out of range");
   end

   op_kind_t          op;
   logic [BLK_W-1:0]  cam_blk;
   logic [IDX_W-1:0]  cam_idx;
   logic              cam_vo;
   logic              busy, wb_en, merge_en, rec_err;
   logic [WORD_W-1:0] rec_w0, rec_w1, rec_w2, wb_data;
   logic [PRIO_W-1:0] merge_ipb, pipr_nxt;
   logic              push_fire, pull_fire, pull_err_q;

   vpctx_decode #(.ADDR_W(ADDR_W), .PUSH_OFS(PUSH_OFS), .PULL_OFS(PULL_OFS),
                  .BLK_W(BLK_W), .IDX_W(IDX_W)) u_dec (
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .cam(os_cam), .op(op), .cam_blk(cam_blk), .cam_idx(cam_idx), .cam_vo(cam_vo));

   vpctx_table #(.BLK_W(BLK_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .rd_sel(cam_blk),
      .rd_w0(rec_w0), .rd_w1(rec_w1), .rd_w2(rec_w2),
      .wb_en(wb_en), .wb_sel(cam_blk), .wb_data(wb_data),
      .ld_en(tbl_we), .ld_sel(tbl_sel), .ld_word(tbl_word), .ld_data(tbl_data));

   vpctx_seq #(.IDX_W(IDX_W), .PRIO_W(PRIO_W), .TAG_CHECK(TAG_CHECK)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(push_fire && req_wdata[WORD_W-1]),
      .idx(cam_idx), .rec_w0(rec_w0), .rec_w1(rec_w1), .rec_w2(rec_w2),
      .busy(busy), .wb_en(wb_en), .wb_data(wb_data), .merge_en(merge_en),
      .merge_ipb(merge_ipb), .rec_err(rec_err));

   assign req_ready = !busy;
   assign push_fire = !busy && (op == OP_PUSH);
   assign pull_fire = !busy && (op == OP_PULL);

   assign leg_valid = !busy && (op == OP_PASS);
   assign leg_write = req_write;
   assign leg_addr  = req_addr;
   assign leg_wdata = req_wdata;

   always_comb begin
      pipr_nxt = '1;
      for (int i = PRIO_W - 1; i >= 0; i--)
         if (os_ipb[i]) pipr_nxt = i[PRIO_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         os_cam     <= '0;
         os_ipb     <= '0;
         os_pipr    <= '1;
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         pull_err_q <= 1'b0;
      end else begin
         rsp_valid  <= pull_fire;
         pull_err_q <= pull_fire && !cam_vo;
         os_pipr    <= pipr_nxt;
         if (pull_fire) rsp_rdata <= os_cam;
         if (push_fire)      os_cam <= req_wdata;
         else if (pull_fire) os_cam <= {1'b0, os_cam[WORD_W-2:0]};
         if (merge_en) os_ipb <= os_ipb | merge_ipb;
      end
   end

   assign exc_out = (os_pipr < cur_prio);
   assign ctx_err = rec_err || pull_err_q;

   a_r1_push_store : assert property (@(posedge clk) disable iff (!rst_n)
      push_fire |=> os_cam == $past(req_wdata));
   a_r3_stall_after_push : assert property (@(posedge clk) disable iff (!rst_n)
      (push_fire && req_wdata[WORD_W-1]) |=> !req_ready && !leg_valid);
   a_r6_pull_data : assert property (@(posedge clk) disable iff (!rst_n)
      pull_fire |=> rsp_valid && rsp_rdata == $past(os_cam));
   a_r6_pull_clear : assert property (@(posedge clk) disable iff (!rst_n)
      pull_fire |=> !os_cam[WORD_W-1] && os_cam[WORD_W-2:0] == $past(os_cam[WORD_W-2:0]));
   a_r8_pass_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      leg_valid |=> $stable(os_cam));
   a_r5_ipb_only_grows : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (os_ipb & $past(os_ipb)) == $past(os_ipb));
endmodule

// File: tb/tb_vp_ctx_switch.sv
module tb_vp_ctx_switch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, leg_valid, leg_write, exc_out, ctx_err;
   logic [31:0] rsp_rdata, leg_wdata, os_cam;
   logic [11:0] leg_addr;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_sel = '0;
   logic [1:0]  tbl_word = '0;
   logic [31:0] tbl_data = '0;
   logic [7:0]  cur_prio = 8'hFF;
   logic [7:0]  os_ipb, os_pipr;
   int n_chk = 0, n_bad = 0;

   localparam logic [11:0] A_PUSH = 12'h118, A_PULL = 12'h130;

   always #10 clk = ~clk;

   vp_ctx_switch dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [3:0] e, input logic [31:0] w0, w1, w2);
      logic [31:0] w [3];
      w[0] = w0; w[1] = w1; w[2] = w2;
      for (int k = 0; k < 3; k++) begin
         tbl_we = 1'b1; tbl_sel = e; tbl_word = 2'(k); tbl_data = w[k];
         @(negedge clk);
      end
      tbl_we = 1'b0;
   endtask

   // Drives one access at a falling edge; returns at the next falling edge (cycle T+1).
   task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      chk("R9 reset ipb", 32'(os_ipb), 0);
      chk("R9 reset pipr", 32'(os_pipr), 32'hFF);
      chk("R1 reset cam", os_cam, 0);
      chk("R10 reset exc", 32'(exc_out), 0);
      chk("R3 reset ready", 32'(req_ready), 1);
   endtask

   task automatic t_push_novo;
      access(1'b1, A_PUSH, 32'h0512_3456);
      chk("R1 cam stored", os_cam, 32'h0512_3456);
      chk("R2 ready stays", 32'(req_ready), 1);
      chk("R2 no err", 32'(ctx_err), 0);
      @(negedge clk);
      chk("R2 no err later", 32'(ctx_err), 0);
      chk("R2 ipb unchanged", 32'(os_ipb), 0);
   endtask

   task automatic t_push_merge;
      access(1'b1, A_PUSH, 32'h8300_0042);
      chk("R1 cam stored valid", os_cam, 32'h8300_0042);
      chk("R3 busy c1", 32'(req_ready), 0);
      chk("R4 no err c1", 32'(ctx_err), 0);
      @(negedge clk);
      chk("R3 busy c2", 32'(req_ready), 0);
      chk("R4 present no err", 32'(ctx_err), 0);
      chk("R5 not yet merged", 32'(os_ipb), 0);
      @(negedge clk);
      chk("R3 busy c3", 32'(req_ready), 0);
      chk("R5 merged ipb", 32'(os_ipb), 32'h28);
      chk("R9 pipr lags", 32'(os_pipr), 32'hFF);
      @(negedge clk);
      chk("R3 ready c4", 32'(req_ready), 1);
      chk("R9 pipr lowest", 32'(os_pipr), 3);
      chk("R10 exc high", 32'(exc_out), 1);
      cur_prio = 8'h03; #1;
      chk("R10 exc equal", 32'(exc_out), 0);
      cur_prio = 8'h04; #1;
      chk("R10 exc lower", 32'(exc_out), 1);
      cur_prio = 8'hFF;
      // second push of same record: field was drained, word 0 intact
      access(1'b1, A_PUSH, 32'h8300_0042);
      @(negedge clk);
      chk("R5 record still valid", 32'(ctx_err), 0);
      @(negedge clk);
      chk("R5 field drained", 32'(os_ipb), 32'h28);
      @(negedge clk);
   endtask

   task automatic t_push_err(input logic [31:0] cam, input string tag);
      access(1'b1, A_PUSH, cam);
      chk({tag, " no err c1"}, 32'(ctx_err), 0);
      @(negedge clk);
      chk({tag, " err pulse"}, 32'(ctx_err), 1);
      @(negedge clk);
      chk({tag, " err gone"}, 32'(ctx_err), 0);
      chk({tag, " cam kept"}, os_cam, cam);
      chk({tag, " ipb kept"}, 32'(os_ipb), 32'h28);
      @(negedge clk);
      chk("R3 ready back", 32'(req_ready), 1);
   endtask

   task automatic t_stall;
      access(1'b1, A_PUSH, 32'h8700_0011);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h040; #1;
      for (int k = 0; k < 3; k++) begin
         chk("R3 no forward while busy", 32'(leg_valid), 0);
         @(negedge clk); #1;
      end
      chk("R3 forward after busy", 32'(leg_valid), 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R5 empty field no change", 32'(os_ipb), 32'h28);
   endtask

   task automatic t_pull;
      access(1'b0, A_PULL, 32'h0);
      chk("R6 rsp valid", 32'(rsp_valid), 1);
      chk("R6 old word", rsp_rdata, 32'h8700_0011);
      chk("R6 vo cleared", os_cam, 32'h0700_0011);
      chk("R7 no err valid pull", 32'(ctx_err), 0);
      access(1'b0, A_PULL, 32'h0);
      chk("R7 data still returned", rsp_rdata, 32'h0700_0011);
      chk("R7 err pulse", 32'(ctx_err), 1);
      @(negedge clk);
      chk("R7 err one cycle", 32'(ctx_err), 0);
      chk("R6 rsp one cycle", 32'(rsp_valid), 0);
   endtask

   task automatic t_legacy;
      req_valid = 1'b1; req_write = 1'b1; req_addr = A_PULL; req_wdata = 32'hDEAD_0001; #1;
      chk("R8 fwd valid", 32'(leg_valid), 1);
      chk("R8 fwd addr", 32'(leg_addr), 32'(A_PULL));
      chk("R8 fwd data", leg_wdata, 32'hDEAD_0001);
      chk("R8 fwd dir", 32'(leg_write), 1);
      @(negedge clk);
      req_write = 1'b0; req_addr = A_PUSH; #1;
      chk("R8 load of push ofs fwd", 32'(leg_valid), 1);
      chk("R8 fwd dir load", 32'(leg_write), 0);
      @(negedge clk);
      req_valid = 1'b0; #1;
      chk("R8 cam untouched", os_cam, 32'h0700_0011);
      chk("R8 no rsp", 32'(rsp_valid), 0);
   endtask

   task automatic t_top_prio;
      access(1'b1, A_PUSH, 32'h8C00_0007);
      repeat (3) @(negedge clk);
      chk("R5 merge second", 32'(os_ipb), 32'h29);
      chk("R9 pipr zero", 32'(os_pipr), 0);
      cur_prio = 8'h01; #1;
      chk("R10 exc prio 0", 32'(exc_out), 1);
      cur_prio = 8'h00; #1;
      chk("R10 exc none", 32'(exc_out), 0);
   endtask

   initial begin : wdog
      repeat (5000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_push_novo();
      load(4'd3, 32'h8000_0000, 32'h0000_0042, 32'h2800_0000);       // R11
      load(4'd7, 32'h8000_0000, 32'h0000_0011, 32'h0000_0000);
      load(4'd9, 32'h0000_0000, 32'h0000_0005, 32'hFF00_0000);
      load(4'd12, 32'h8000_0000, 32'h0000_0007, 32'h0100_0000);
      t_push_merge();
      t_push_err(32'h8300_0099, "R4 tag miss");
      t_push_err(32'h8900_0005, "R4 invalid record");
      t_stall();
      t_pull();
      t_legacy();
      t_top_prio();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule